// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block holds two address pointers and a small configuration byte. One pointer at a time is active, and the active pointer drives the address output. A neighbouring instruction decoder pulses single-cycle strobes for the operations that use the pointer: step it, load it with an immediate value, or use it for an external data read or write. Each pointer has its own counting direction, so the step strobe can move one pointer up while the other moves down.

When the toggle mode is enabled, the active-pointer select inverts itself after every cycle that carries a pointer operation. A block-copy loop can then read through one pointer, write through the other, and step both, with no writes to the configuration byte inside the loop. Software reads and writes the pointers and the configuration byte through a byte-wide register port.

Top module: `dual_dptr_unit`

## Requirements
- R1: Bit 0 of the configuration byte (register address 4) selects the active pointer: 0 selects pointer A and 1 selects pointer B. `addr_o` is combinational and equals the active pointer as it stands before the current clock edge.
- R2: With the active pointer's direction bit clear, `step_stb` adds one to the active pointer and leaves the other pointer unchanged. The count wraps from 0xFFFF to 0x0000.
- R3: Bit 2 of the configuration byte is pointer A's direction bit and bit 3 is pointer B's. When the active pointer's direction bit is set, `step_stb` subtracts one instead of adding. The count wraps from 0x0000 to 0xFFFF.
- R4: `load_stb` writes `load_val` into the active pointer. When `load_stb` and `step_stb` are asserted in the same cycle, the load wins.
- R5: Bit 1 of the configuration byte enables toggle mode. While it is set, each cycle with any of `step_stb`, `load_stb`, `xrd_stb` or `xwr_stb` asserted inverts the select bit exactly once. While it is clear, the strobes leave the select bit unchanged.
- R6: `xrd_stb` and `xwr_stb` never change either pointer value.
- R7: Register addresses: 0 is pointer A's low byte, 1 is pointer A's high byte, 2 is pointer B's low byte, 3 is pointer B's high byte, and 4 is the configuration byte. Writes take effect on the next edge. Bits 7:4 of the configuration byte read as 0. Addresses 5 to 7 read as 0, and writes to them change nothing.
- R8: After reset, both pointers, the select bit, the toggle bit and both direction bits are 0.
- R9: A register write to the configuration byte in the same cycle as a toggling operation sets the select bit from the written data, and the toggle is dropped.
- R10: A register write to a byte of a pointer in the same cycle as a step or load of that pointer updates only the written byte. The other byte keeps its old value and the operation is dropped for that pointer. The toggle still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_stb | input | 1 | Step the active pointer by one in its direction |
| load_stb | input | 1 | Load `load_val` into the active pointer |
| load_val | input | 16 | Immediate value for a load |
| xrd_stb | input | 1 | External data read through the active pointer |
| xwr_stb | input | 1 | External data write through the active pointer |
| reg_we | input | 1 | Register port write enable |
| reg_addr | input | 3 | Register port byte address |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data, combinational |
| addr_o | output | 16 | Active pointer value |

## Verification
The checker tests on every cycle the rules that can be stated locally in time: steps in each direction, loads, transfers that leave both pointers unchanged, a select bit that inverts only on a toggling operation, and priority of a configuration write over the toggle. Idle stability and zero readback of unused bits are also checked every cycle. Other behaviour appears only in the bench's scenarios against its cycle-level model. This covers wrap-around at both ends, partial byte writes colliding with operations, and alternation of the pointers through a copy loop. It also covers a long stream of mixed strobes and register accesses.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
   localparam int NUM_PTR  = 2;
   localparam int SEL_BIT  = 0;
   localparam int TOG_BIT  = 1;
   localparam int DIR_LSB  = 2;
   localparam int CFG_USED = DIR_LSB + NUM_PTR;

   typedef struct packed {
      logic step;
      logic load;
      logic xrd;
      logic xwr;
   } ptr_op_t;
endpackage

// File: rtl/dptr_ptr_reg.sv
module dptr_ptr_reg #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W/8-1:0] byte_we,
   input  logic [7:0]        wbyte,
   input  logic              step_en,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              count_down,
   output logic [ADDR_W-1:0] q
);
   localparam int NB = ADDR_W / 8;
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] nxt;
   logic [ADDR_W-1:0] stepped;

   // direction chosen per pointer
   assign stepped = count_down ? (q - ONE) : (q + ONE);

   always_comb begin
      nxt = q;
      if (|byte_we) begin
         for (int b = 0; b < NB; b++) begin
            if (byte_we[b]) nxt[b*8 +: 8] = wbyte;
         end
      end else if (load_en) begin
         nxt = load_val;
      end else if (step_en) begin
         nxt = stepped;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/dptr_sel_ctrl.sv
module dptr_sel_ctrl
   import dptr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [7:0]         cfg_wdata,
   input  logic               op_any,
   output logic               sel,
   output logic               tog_en,
   output logic [NUM_PTR-1:0] down,
   output logic [7:0]         cfg_rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel    <= 1'b0;
         tog_en <= 1'b0;
         down   <= '0;
      end else if (cfg_we) begin
         // software write outranks the automatic toggle
         sel    <= cfg_wdata[SEL_BIT];
         tog_en <= cfg_wdata[TOG_BIT];
         down   <= cfg_wdata[DIR_LSB +: NUM_PTR];
      end else if (op_any && tog_en) begin
         sel    <= ~sel;
      end
   end

   always_comb begin
      cfg_rdata                    = '0;
      cfg_rdata[SEL_BIT]           = sel;
      cfg_rdata[TOG_BIT]           = tog_en;
      cfg_rdata[DIR_LSB +: NUM_PTR] = down;
   end
endmodule

// File: rtl/dptr_reg_port.sv
module dptr_reg_port
   import dptr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int REG_AW = 3
) (
   input  logic                        reg_we,
   input  logic [REG_AW-1:0]           reg_addr,
   input  logic [NUM_PTR*ADDR_W-1:0]   ptr_flat,
   input  logic [7:0]                  cfg_rdata,
   output logic [NUM_PTR*ADDR_W/8-1:0] byte_we,
   output logic                        cfg_we,
   output logic [7:0]                  reg_rdata
);
   localparam int NB       = ADDR_W / 8;
   localparam int NBYTES   = NUM_PTR * NB;
   localparam int CFG_ADDR = NBYTES;

   for (genvar i = 0; i < NBYTES; i++) begin : g_bwe
      assign byte_we[i] = reg_we && (reg_addr == REG_AW'(i));
   end

   assign cfg_we = reg_we && (reg_addr == REG_AW'(CFG_ADDR));

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (reg_addr == REG_AW'(i)) reg_rdata = ptr_flat[i*8 +: 8];
      end
      if (reg_addr == REG_AW'(CFG_ADDR)) reg_rdata = cfg_rdata;
   end
endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
   import dptr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int REG_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_stb,
   input  logic              load_stb,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              xrd_stb,
   input  logic              xwr_stb,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int NB     = ADDR_W / 8;
   localparam int NBYTES = NUM_PTR * NB;

   if ((ADDR_W % 8) != 0 || ADDR_W < 8) begin : g_chk_w
      $error("ADDR_W must be a non-zero multiple of 8");
   end
   if ((1 << REG_AW) < NBYTES + 1) begin : g_chk_aw
      $error("REG_AW too narrow for the register map");
   end

   ptr_op_t                   op;
   logic                      op_any;
   logic                      sel_q;
   logic                      tog_q;
   logic [NUM_PTR-1:0]        down_q;
   logic [7:0]                cfg_rdata;
   logic                      cfg_we;
   logic [NBYTES-1:0]         byte_we;
   logic [NUM_PTR*ADDR_W-1:0] ptr_flat;

   assign op     = '{step: step_stb, load: load_stb, xrd: xrd_stb, xwr: xwr_stb};
   assign op_any = |op;

   dptr_sel_ctrl u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (reg_wdata),
      .op_any    (op_any),
      .sel       (sel_q),
      .tog_en    (tog_q),
      .down      (down_q),
      .cfg_rdata (cfg_rdata)
   );

   dptr_reg_port #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_port (
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .ptr_flat  (ptr_flat),
      .cfg_rdata (cfg_rdata),
      .byte_we   (byte_we),
      .cfg_we    (cfg_we),
      .reg_rdata (reg_rdata)
   );

   for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
      logic is_act;
      assign is_act = (sel_q == p[0]);
      dptr_ptr_reg #(.ADDR_W(ADDR_W)) u_ptr (
         .clk        (clk),
         .rst_n      (rst_n),
         .byte_we    (byte_we[p*NB +: NB]),
         .wbyte      (reg_wdata),
         .step_en    (op.step && is_act),
         .load_en    (op.load && is_act),
         .load_val   (load_val),
         .count_down (down_q[p]),
         .q          (ptr_flat[p*ADDR_W +: ADDR_W])
      );
   end

   assign addr_o = ptr_flat[sel_q*ADDR_W +: ADDR_W];
endmodule

// File: rtl/dual_dptr_unit_chk.sv
module dual_dptr_unit_chk #(
   parameter int ADDR_W = 16,
   parameter int REG_AW = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                step_stb,
   input logic                load_stb,
   input logic [ADDR_W-1:0]   load_val,
   input logic                xrd_stb,
   input logic                xwr_stb,
   input logic                reg_we,
   input logic [REG_AW-1:0]   reg_addr,
   input logic [7:0]          reg_wdata,
   input logic [7:0]          reg_rdata,
   input logic [ADDR_W-1:0]   addr_o,
   input logic                sel_q,
   input logic                tog_q,
   input logic [1:0]          down_q,
   input logic [2*ADDR_W-1:0] ptr_flat
);
   localparam logic [REG_AW-1:0] CFG_A = REG_AW'(2 * ADDR_W / 8);
   localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);

   logic [ADDR_W-1:0] pa, pb;
   logic              any_op, cfg_wr;
   assign pa     = ptr_flat[ADDR_W-1:0];
   assign pb     = ptr_flat[2*ADDR_W-1:ADDR_W];
   assign any_op = step_stb | load_stb | xrd_stb | xwr_stb;
   assign cfg_wr = reg_we && (reg_addr == CFG_A);

   AST_STEP_UP_A: assert property (@(posedge clk) disable iff (!rst_n)
      (step_stb && !load_stb && !reg_we && !sel_q && !down_q[0]) |=> pa == $past(pa) + ONE); // R2
   AST_STEP_DOWN_B: assert property (@(posedge clk) disable iff (!rst_n)
      (step_stb && !load_stb && !reg_we && sel_q && down_q[1]) |=> pb == $past(pb) - ONE); // R3
   AST_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && !reg_we && !sel_q) |=> pa == $past(load_val)); // R4
   AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((xrd_stb || xwr_stb) && !step_stb && !load_stb && !reg_we) |=> $stable(ptr_flat)); // R6
   AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (any_op && tog_q && !cfg_wr) |=> sel_q != $past(sel_q)); // R5
   AST_TOGGLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!tog_q && !cfg_wr) |=> $stable(sel_q)); // R5
   AST_CFG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> sel_q == $past(reg_wdata[0])); // R9
   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr >= CFG_A) |-> reg_rdata[7:4] == 4'h0); // R7
   AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_op && !reg_we) |=> $stable(addr_o)); // R1
endmodule

bind dual_dptr_unit dual_dptr_unit_chk #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .step_stb  (step_stb),
   .load_stb  (load_stb),
   .load_val  (load_val),
   .xrd_stb   (xrd_stb),
   .xwr_stb   (xwr_stb),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .addr_o    (addr_o),
   .sel_q     (sel_q),
   .tog_q     (tog_q),
   .down_q    (down_q),
   .ptr_flat  (ptr_flat)
);

// File: tb/tb_dual_dptr_unit.sv
module tb_dual_dptr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_stb = 0, load_stb = 0, xrd_stb = 0, xwr_stb = 0, reg_we = 0;
   logic [15:0] load_val = '0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [15:0] addr_o;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   // behavioural reference state
   logic [15:0] mp [2];
   logic        msel, mtog;
   logic [1:0]  mdir;

   always #10 clk = ~clk;

   dual_dptr_unit dut (
      .clk(clk), .rst_n(rst_n), .step_stb(step_stb), .load_stb(load_stb),
      .load_val(load_val), .xrd_stb(xrd_stb), .xwr_stb(xwr_stb),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .addr_o(addr_o)
   );

   function automatic logic [7:0] mread(input int a);
      case (a)
         0: return mp[0][7:0];
         1: return mp[0][15:8];
         2: return mp[1][7:0];
         3: return mp[1][15:8];
         4: return {4'h0, mdir, mtog, msel};
         default: return 8'h00;
      endcase
   endfunction

   task automatic cmp(input string req, input string what, input int act, input int exp);
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic s, input logic l, input logic r, input logic w,
                       input logic we, input int a, input logic [7:0] wd,
                       input logic [15:0] lv, input string req);
      int act_p;
      @(negedge clk);
      step_stb = s; load_stb = l; xrd_stb = r; xwr_stb = w;
      reg_we = we; reg_addr = 3'(a); reg_wdata = wd; load_val = lv;
      #2;
      vectors++;
      cmp(req, "addr_o", int'(addr_o), int'(mp[msel]));
      cmp(req, "reg_rdata", int'(reg_rdata), int'(mread(a)));
      @(posedge clk);
      #1;
      act_p = msel ? 1 : 0;
      // pointer bytes
      if (we && a < 4) begin
         if (a % 2 == 0) mp[a/2][7:0] = wd; else mp[a/2][15:8] = wd;
      end
      if (!(we && a < 4 && a/2 == act_p)) begin
         if (l) mp[act_p] = lv;
         else if (s) mp[act_p] = mdir[act_p] ? mp[act_p] - 16'd1 : mp[act_p] + 16'd1;
      end
      if (we && a == 4) begin
         msel = wd[0]; mtog = wd[1]; mdir = wd[3:2];
      end else if ((s || l || r || w) && mtog) begin
         msel = ~msel;
      end
   endtask

   task automatic rd(input int a, input string req);
      step(0, 0, 0, 0, 0, a, 8'h00, 16'h0000, req);
   endtask

   task automatic wr(input int a, input logic [7:0] d, input string req);
      step(0, 0, 0, 0, 1, a, d, 16'h0000, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      mp[0] = 0; mp[1] = 0; msel = 0; mtog = 0; mdir = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8 reset state readback
      for (int a = 0; a < 8; a++) rd(a, "R8");
      // R7 register writes and readback
      wr(0, 8'h34, "R7"); wr(1, 8'h12, "R7"); wr(2, 8'hFF, "R7"); wr(3, 8'hFF, "R7");
      wr(5, 8'hAA, "R7"); wr(7, 8'h55, "R7"); wr(4, 8'hF0, "R7");
      for (int a = 0; a < 8; a++) rd(a, "R7");
      // R2 step up on A, then on B with wrap
      step(1, 0, 0, 0, 0, 0, 0, 0, "R2");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R2");
      wr(4, 8'h01, "R1");
      rd(0, "R1");
      step(1, 0, 0, 0, 0, 2, 0, 0, "R2");
      rd(2, "R2"); rd(3, "R2"); rd(0, "R2");
      // R3 count down on B through zero, A untouched
      wr(4, 8'h09, "R3");
      step(1, 0, 0, 0, 0, 2, 0, 0, "R3");
      step(1, 0, 0, 0, 0, 3, 0, 0, "R3");
      wr(4, 8'h04, "R3");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
      rd(0, "R3");
      // R4 load, and load beating step
      step(0, 1, 0, 0, 0, 0, 0, 16'hBEEF, "R4");
      step(1, 1, 0, 0, 0, 1, 0, 16'h0100, "R4");
      rd(1, "R4");
      // R6 transfers leave pointers alone
      step(0, 0, 1, 0, 0, 0, 0, 16'h5555, "R6");
      step(0, 0, 0, 1, 0, 1, 0, 16'h5555, "R6");
      rd(0, "R6");
      // R5 copy loop with toggle on, both counting up
      wr(0, 8'h00, "R5"); wr(1, 8'h40, "R5"); wr(2, 8'h00, "R5"); wr(3, 8'h80, "R5");
      wr(4, 8'h02, "R5");
      for (int i = 0; i < 4; i++) begin
         step(0, 0, 1, 0, 0, 4, 0, 0, "R5");
         step(0, 0, 0, 1, 0, 4, 0, 0, "R5");
         step(1, 0, 0, 0, 0, 4, 0, 0, "R5");
         step(1, 0, 0, 0, 0, 4, 0, 0, "R5");
      end
      rd(0, "R5"); rd(2, "R5");
      // R5 toggle off: select holds
      wr(4, 8'h00, "R5");
      step(0, 0, 1, 0, 0, 4, 0, 0, "R5");
      rd(4, "R5");
      // R9 configuration write collides with a toggling op
      wr(4, 8'h02, "R9");
      step(1, 0, 0, 0, 1, 4, 8'h02, 0, "R9");
      rd(4, "R9");
      step(0, 0, 1, 0, 1, 4, 8'h03, 0, "R9");
      rd(4, "R9");
      // R10 byte write collides with step/load on the active pointer
      wr(4, 8'h00, "R10");
      wr(0, 8'hFF, "R10"); wr(1, 8'h00, "R10");
      step(1, 0, 0, 0, 1, 1, 8'h77, 0, "R10");
      rd(0, "R10"); rd(1, "R10");
      step(0, 1, 0, 0, 1, 0, 8'h11, 16'hCAFE, "R10");
      rd(0, "R10"); rd(1, "R10");
      wr(4, 8'h02, "R10");
      step(1, 0, 0, 0, 1, 0, 8'h22, 0, "R10");
      rd(4, "R10"); rd(0, "R10");
      // R1 mixed stream against the model
      lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[0], lf[1] & lf[2], lf[3], lf[4], (lf[7:5] == 3'b000),
              int'(lf[10:8]), lf[15:8], {lf[7:0], lf[15:8]}, "R1");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule